// File: doc/BRIEF.md
# Serial ADC Command Front End

This block is the device-side serial port of a 12-bit successive-approximation converter. It runs on a fast system clock. The host's chip select, serial clock and data line are brought in through synchronizer flops, and the block acts on the edges of the serial clock that it detects.

While chip select is active, the block waits for a start bit and then collects an 8-bit command. It decodes the input channel, the polarity, the input mode and the clock mode from that command and holds them for the parent logic. When the command selects external-clock mode, the block serializes the most recent converter sample onto the data-out pin. Each result bit is launched on a falling serial-clock edge, so the host can sample it on the next rising edge.

The sample path from the converter stub is valid-only: `conv_done` marks a new `sample_data` word in that cycle, and there is no ready signal. The converter cannot be stalled, so each strobe overwrites the held sample. The serial side has no back-pressure either, because the host owns the clock.

Top module: `adc_cmd_front_end`

## Requirements
- R1: After chip select falls, data bits equal to 0 on rising serial-clock edges are ignored, however many there are. The first 1 is taken as the start bit and becomes bit 7 of the command.
- R2: The eight command bits arrive MSB first, with bit 7 = start. Bits 6:4 give the channel (0 to 7, with bit 6 as its MSB). Bit 3 = 1 selects unipolar. Bit 2 = 1 selects single-ended. Bits 1:0 give the clock mode. `byte_valid` pulses for exactly one clock once the eighth bit is taken, and the decoded fields hold until the next complete command.
- R3: `acquire` is high from the moment the fifth command bit is taken until the eighth is taken. During that window the last three command bits are arriving. It is low at every other time.
- R4: Only clock mode 2'b11 (external clock) starts a result transfer. Any other mode still decodes and pulses `byte_valid`, but `dout` stays 0 and the block goes back to waiting for a start bit.
- R5: In external-clock mode, the 16 falling edges that begin with the one closing the command launch the following on `dout`: a single 0, then the result bits B11 down to B0, then three 0s. A host sampling on rising edges 9 to 24 therefore reads {0, B11..B0, 000}.
- R6: In unipolar mode the result equals the held sample, in straight binary. In bipolar mode the sample's MSB is inverted, which turns the offset-binary code into two's complement.
- R7: A `conv_done` strobe latches `sample_data`. The value sent is the last one latched before the falling edge that closes the command.
- R8: Raising chip select abandons any partial command or transfer. `acquire` and `dout` drop, no `byte_valid` is produced, and the next frame is decoded from scratch.
- R9: After reset, every output is 0. `dout` is 0 whenever no result bit is being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command data |
| conv_done | input | 1 | Sample-valid strobe from the converter stub |
| sample_data | input | 12 | Converter sample, offset binary |
| dout | output | 1 | Serial result data |
| byte_valid | output | 1 | One-cycle pulse when a command is complete |
| chan | output | 3 | Decoded channel number |
| unipolar | output | 1 | Decoded polarity (1 = unipolar) |
| single_ended | output | 1 | Decoded input mode (1 = single-ended) |
| clk_mode | output | 2 | Decoded clock-mode field |
| acquire | output | 1 | Acquisition window indicator |

## Verification
A bit counter that is off by one shows up at once. The host reads back a result that is shifted by one position, and `acquire` opens one serial clock early or late; both are visible within the frame that caused the fault. A framing state that stays stuck, or that misses a chip-select abort, shows up on the following frame as decoded fields that are wrong or stale, or as a missing `byte_valid` pulse. A wrong sample-hold or polarity path changes specific result bits. The test patterns are chosen so that a flipped MSB or a stale sample differs in every such case.

// File: rtl/adcfe_pkg.sv
package adcfe_pkg;
  localparam int CMD_BITS = 8;
  localparam int ACQ_BITS = 3;
  localparam logic [1:0] EXT_CLK_MODE = 2'b11;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_CAPTURE,
    ST_RESULT
  } fe_state_t;

  typedef struct packed {
    logic [2:0] chan;
    logic       unipolar;
    logic       single_ended;
    logic [1:0] clk_mode;
  } cmd_fields_t;
endpackage

// File: rtl/adcfe_pin_sync.sv
module adcfe_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic din,
  output logic cs_active,
  output logic din_s,
  output logic sclk_rise,
  output logic sclk_fall
);
  logic [STAGES-1:0] cs_p, sclk_p, din_p;
  logic sclk_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p      <= '1;
      sclk_p    <= '0;
      din_p     <= '0;
      sclk_last <= 1'b0;
    end else begin
      cs_p      <= {cs_p[STAGES-2:0], cs_n};
      sclk_p    <= {sclk_p[STAGES-2:0], sclk};
      din_p     <= {din_p[STAGES-2:0], din};
      sclk_last <= sclk_p[STAGES-1];
    end
  end

  assign cs_active = ~cs_p[STAGES-1];
  assign din_s     = din_p[STAGES-1];
  assign sclk_rise = cs_active &  sclk_p[STAGES-1] & ~sclk_last;
  assign sclk_fall = cs_active & ~sclk_p[STAGES-1] &  sclk_last;
endmodule

// File: rtl/adcfe_cmd_decode.sv
module adcfe_cmd_decode
  import adcfe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_active,
  input  logic        din_s,
  input  logic        sclk_rise,
  input  logic        frame_done,
  output cmd_fields_t fields,
  output logic        byte_valid,
  output logic        start_tx,
  output logic        acquire
);
  localparam int CW = $clog2(CMD_BITS + 1);

  fe_state_t state;
  logic [CW-1:0] cnt;
  logic [CMD_BITS-1:0] shreg, next_byte;
  cmd_fields_t next_fields;

  assign next_byte = {shreg[CMD_BITS-2:0], din_s};
  assign next_fields = '{chan: next_byte[6:4], unipolar: next_byte[3],
                         single_ended: next_byte[2], clk_mode: next_byte[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_HUNT;
      cnt        <= '0;
      shreg      <= '0;
      fields     <= '0;
      byte_valid <= 1'b0;
      start_tx   <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      start_tx   <= 1'b0;
      if (!cs_active) begin
        state <= ST_HUNT;
        cnt   <= '0;
      end else begin
        case (state)
          ST_HUNT: if (sclk_rise && din_s) begin
            shreg <= {{(CMD_BITS-1){1'b0}}, 1'b1};
            cnt   <= CW'(1);
            state <= ST_CAPTURE;
          end
          ST_CAPTURE: if (sclk_rise) begin
            shreg <= next_byte;
            cnt   <= cnt + CW'(1);
            if (cnt == CW'(CMD_BITS - 1)) begin
              fields     <= next_fields;
              byte_valid <= 1'b1;
              cnt        <= '0;
              if (next_fields.clk_mode == EXT_CLK_MODE) begin
                start_tx <= 1'b1;
                state    <= ST_RESULT;
              end else begin
                state <= ST_HUNT;
              end
            end
          end
          ST_RESULT: if (frame_done) state <= ST_HUNT;
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  assign acquire = (state == ST_CAPTURE) && (cnt >= CW'(CMD_BITS - ACQ_BITS));

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
  // R3
  acq_before_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(acquire));
  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> (!acquire && !byte_valid));
endmodule

// File: rtl/adcfe_result_tx.sv
module adcfe_result_tx #(
  parameter int RES_W = 12,
  parameter int LEAD  = 1,
  parameter int FRAME = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_active,
  input  logic             sclk_fall,
  input  logic             start,
  input  logic             unipolar,
  input  logic             conv_done,
  input  logic [RES_W-1:0] sample,
  output logic             dout,
  output logic             frame_done
);
  localparam int FW = $clog2(FRAME + 1);

  logic [RES_W-1:0] hold, formatted, sh;
  logic [FW-1:0] fcnt;
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= '0;
    else if (conv_done) hold <= sample;
  end

  assign formatted = unipolar ? hold : {~hold[RES_W-1], hold[RES_W-2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      fcnt       <= '0;
      sh         <= '0;
      dout       <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!cs_active) begin
        armed <= 1'b0;
        fcnt  <= '0;
        dout  <= 1'b0;
      end else if (start) begin
        armed <= 1'b1;
        fcnt  <= '0;
        dout  <= 1'b0;
      end else if (armed && sclk_fall) begin
        fcnt <= fcnt + FW'(1);
        if (fcnt < FW'(LEAD)) begin
          dout <= 1'b0;
          if (fcnt == FW'(LEAD - 1)) sh <= formatted;
        end else if (fcnt < FW'(LEAD + RES_W)) begin
          dout <= sh[RES_W-1];
          sh   <= {sh[RES_W-2:0], 1'b0};
        end else begin
          dout <= 1'b0;
        end
        if (fcnt == FW'(FRAME - 1)) begin
          armed      <= 1'b0;
          frame_done <= 1'b1;
        end
      end
    end
  end

  // R8
  cs_high_dout_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> !dout);
  // R9
  dout_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout |-> armed);
endmodule

// File: rtl/adc_cmd_front_end.sv
module adc_cmd_front_end
  import adcfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RES_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  input  logic             conv_done,
  input  logic [RES_W-1:0] sample_data,
  output logic             dout,
  output logic             byte_valid,
  output logic [2:0]       chan,
  output logic             unipolar,
  output logic             single_ended,
  output logic [1:0]       clk_mode,
  output logic             acquire
);
  localparam int LEAD_ZEROS = 1;
  localparam int FRAME_LEN  = 2 * CMD_BITS;

  logic cs_active, din_s, sclk_rise, sclk_fall, start_tx, frame_done;
  cmd_fields_t fields;

  adcfe_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .cs_active(cs_active), .din_s(din_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
  );

  adcfe_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .din_s(din_s),
    .sclk_rise(sclk_rise), .frame_done(frame_done), .fields(fields),
    .byte_valid(byte_valid), .start_tx(start_tx), .acquire(acquire)
  );

  adcfe_result_tx #(.RES_W(RES_W), .LEAD(LEAD_ZEROS), .FRAME(FRAME_LEN)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .sclk_fall(sclk_fall),
    .start(start_tx), .unipolar(fields.unipolar), .conv_done(conv_done),
    .sample(sample_data), .dout(dout), .frame_done(frame_done)
  );

  assign chan         = fields.chan;
  assign unipolar     = fields.unipolar;
  assign single_ended = fields.single_ended;
  assign clk_mode     = fields.clk_mode;
endmodule

// File: tb/sim_adc_cmd_front_end.sv
module sim_adc_cmd_front_end;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic conv_done = 1'b0;
  logic [11:0] sample_data = '0;
  logic dout, byte_valid, unipolar, single_ended, acquire;
  logic [2:0] chan;
  logic [1:0] clk_mode;

  int checks = 0, errors = 0, bv_cnt = 0;
  logic [15:0] rx_bits = '0;

  typedef struct { logic [15:0] bits; string req; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  adc_cmd_front_end u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .conv_done(conv_done), .sample_data(sample_data), .dout(dout),
    .byte_valid(byte_valid), .chan(chan), .unipolar(unipolar),
    .single_ended(single_ended), .clk_mode(clk_mode), .acquire(acquire)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (byte_valid) bv_cnt++;

  // monitor: master samples dout on every rising sclk edge
  always @(posedge sclk) if (!cs_n) rx_bits = {rx_bits[14:0], dout};

  // scoreboard: pop and compare at the end of each frame
  always @(posedge cs_n) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(rx_bits == e.bits, e.req, int'(rx_bits), int'(e.bits));
    end
  end

  task automatic sbit(input logic b);
    @(negedge clk) din = b;
    repeat (H) @(negedge clk);
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic load_sample(input logic [11:0] s);
    @(negedge clk) begin sample_data = s; conv_done = 1'b1; end
    @(negedge clk) conv_done = 1'b0;
  endtask

  // drives one frame; mid_en updates the sample while the command is arriving
  task automatic frame(input int lead, input logic [7:0] cmd, input logic [11:0] smp,
                       input bit mid_en, input logic [11:0] mid_smp, input string req);
    exp_t e;
    logic [11:0] used, code;
    int bv0;
    load_sample(smp);
    used = mid_en ? mid_smp : smp;
    code = cmd[3] ? used : (used ^ 12'h800);
    e.bits = (cmd[1:0] == 2'b11) ? {1'b0, code, 3'b000} : 16'h0000;
    e.req  = req;
    sb.push_back(e);
    bv0 = bv_cnt;
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < lead; i++) sbit(1'b0);
    for (int k = 1; k <= 8; k++) begin
      sbit(cmd[8-k]);
      if (k == 3 && mid_en) load_sample(mid_smp);
      // R3 acquire window is bits 5..7 received
      if (k == 4 || k == 5 || k == 7 || k == 8)
        check(acquire == (k >= 5 && k <= 7), "R3 acquire window", int'(acquire), int'(k >= 5 && k <= 7));
    end
    // R1 R2 field decode and one pulse
    check({chan, unipolar, single_ended, clk_mode} == cmd[6:0], "R1 R2 fields",
          int'({chan, unipolar, single_ended, clk_mode}), int'(cmd[6:0]));
    check(bv_cnt == bv0 + 1, "R2 byte_valid pulse count", bv_cnt - bv0, 1);
    for (int i = 0; i < 16; i++) sbit(1'b0);
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check(dout == 1'b0, "R9 dout idle", int'(dout), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check({dout, byte_valid, chan, unipolar, single_ended, clk_mode, acquire} == '0,
          "R9 reset outputs", int'({dout, byte_valid, chan, unipolar, single_ended, clk_mode, acquire}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    frame(0, 8'hBF, 12'hA5C, 0, 12'h0, "R5 R6 unipolar result");
    frame(5, 8'hE3, 12'h123, 0, 12'h0, "R1 R6 bipolar after leading zeros");
    frame(2, 8'hFB, 12'hFFF, 0, 12'h0, "R5 all ones unipolar");
    frame(0, 8'h87, 12'h000, 0, 12'h0, "R6 bipolar zero code");
    frame(1, 8'h9C, 12'hFFF, 0, 12'h0, "R4 non external mode keeps dout low");
    frame(0, 8'hAF, 12'h111, 1, 12'hC3A, "R7 latest latched sample");
    begin : abort_case
      int bv0;
      bv0 = bv_cnt;
      @(negedge clk) cs_n = 1'b0;
      repeat (4) @(negedge clk);
      sbit(1'b1); sbit(1'b1); sbit(1'b0); sbit(1'b1); sbit(1'b1); sbit(1'b1);
      check(acquire == 1'b1, "R3 acquire open before abort", int'(acquire), 1);
      @(negedge clk) cs_n = 1'b1;
      repeat (6) @(negedge clk);
      check(acquire == 1'b0, "R8 acquire dropped on abort", int'(acquire), 0);
      check(dout == 1'b0, "R8 dout low on abort", int'(dout), 0);
      check(bv_cnt == bv0, "R8 no byte_valid for partial command", bv_cnt - bv0, 0);
    end
    frame(3, 8'hCB, 12'h5A5, 0, 12'h0, "R8 clean frame after abort");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule